// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readback Port

This block models the digital face of a delta-sigma converter. A conversion engine hands it a finished result on a one-cycle conversion tick. The block clips that result to a 24-bit two's complement word. It then signals availability on one shared output pin: the pin goes low when a word is waiting, and after that the same pin carries the word bit by bit as an external host toggles a serial clock.

A host reads by counting serial clock edges. Rising edge n shows bit 24-n. A 25th rising edge parks the pin high. The falling edge of a 26th clock requests a self-calibration. Holding the serial clock high during readback puts the block into standby, and a low level wakes it again.

The channel-select, buffer-enable and temperature-enable pins are synchronised and watched. Any change on them restarts conversion, and the pin is then held high until the filter has seen enough conversions to settle. All timing is counted in system clock cycles or in conversion ticks, so it scales with the clock.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted, `dout_rdy` is 1, `stby` is 0, `cal_req` is 0 and `chan_oh` is 4'b0001.
- R2: A conversion tick with no pending settle or calibration makes `dout_rdy` high for exactly one cycle. In the next cycle it goes low (data waiting).
- R3: Each synchronised SCLK rising edge puts the next bit of the word on `dout_rdy`, most significant bit first. After the 24th edge, the pin keeps showing bit 0.
- R4: The 25th SCLK rising edge forces `dout_rdy` high. It stays high until new data is presented.
- R5: The falling edge of the 26th SCLK pulses `cal_req` for one cycle and keeps `dout_rdy` high. The next CAL_SKIP ticks (default 2) are discarded, and the tick after them presents data.
- R6: A change on `sel_in`, `buf_en_in` or `temp_en_in` forces `dout_rdy` high. The next SETTLE-1 ticks (default 2) are discarded, and the SETTLE-th tick presents data. A tick in the same cycle as the detected change is not counted.
- R7: `chan_oh` is one-hot, with bit n set for `sel_in` code n (code 2'b00 selects the first channel, bit 0).
- R8: The presented word is `conv_raw` clipped to 24 bits. Values above 8388607 give 24'h7FFFFF, values below -8388608 give 24'h800000, and values in range keep their low 24 bits.
- R9: If SCLK stays high for STBY_CYC cycles while data is waiting or being read, `stby` goes to 1 and `dout_rdy` to 1. Ticks are then ignored. SCLK low exits standby, and the next tick presents data.
- R10: If standby is entered on the 26th SCLK high level, then on wakeup `cal_req` pulses and the calibration of R5 follows.
- R11: A tick that arrives while a word is waiting or being read replaces it with the new word, which is read from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| conv_tick | input | 1 | One-cycle pulse: a conversion finished |
| conv_raw | input | RAW_W | Signed unclipped conversion result |
| sclk_in | input | 1 | Asynchronous serial clock from host |
| sel_in | input | 2 | Asynchronous channel-select code |
| buf_en_in | input | 1 | Asynchronous input-buffer enable |
| temp_en_in | input | 1 | Asynchronous temperature-sensor enable |
| dout_rdy | output | 1 | Shared ready-low / serial data pin |
| cal_req | output | 1 | One-cycle calibration request |
| stby | output | 1 | High while in standby |
| chan_oh | output | 4 | One-hot selected channel |

## Verification
A detected control-pin change and a conversion tick can land on the same clock edge. The restart must win, and the tick must not be counted toward settling. The bench provokes this by toggling a control pin and asserting the tick exactly two negative edges later, which is the cycle the synchroniser reports the change. It then judges that three further ticks are still needed before the pin falls. The same care applies to a tick arriving mid-readback. There the new word must win over the pending SCLK edge, and the bench reads the full replacement word back.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RAW_W    = 26,
  parameter int DATA_W   = 24,
  parameter int SETTLE   = 3,
  parameter int CAL_SKIP = 2,
  parameter int STBY_CYC = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    conv_tick,
  input  logic signed [RAW_W-1:0] conv_raw,
  input  logic                    sclk_in,
  input  logic [1:0]              sel_in,
  input  logic                    buf_en_in,
  input  logic                    temp_en_in,
  output logic                    dout_rdy,
  output logic                    cal_req,
  output logic                    stby,
  output logic [3:0]              chan_oh
);
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam int SK_W  = $clog2(SETTLE + CAL_SKIP + 1);
  localparam int HI_W  = $clog2(STBY_CYC + 1);
  localparam logic signed [RAW_W-1:0] HI_LIM = RAW_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [RAW_W-1:0] LO_LIM = -HI_LIM - 1;

  typedef enum logic [2:0] {P_IDLE, P_UPD, P_RDY, P_SHIFT, P_HIGH, P_CAL, P_STBY} phase_t;

  phase_t            phase;
  logic [1:0]        sclk_sy;
  logic              sclk_d;
  logic [3:0]        ctl_m, ctl_s, ctl_d;
  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  bitn;
  logic [SK_W-1:0]   skip;
  logic [HI_W-1:0]   hi_cnt;
  logic              cal_pend;

  wire sclk_s   = sclk_sy[1];
  wire rise     = sclk_s & ~sclk_d;
  wire fall     = ~sclk_s & sclk_d;
  wire ctl_chg  = ctl_s != ctl_d;
  wire readback = (phase == P_RDY) || (phase == P_SHIFT) || (phase == P_HIGH);
  wire stby_go  = readback && sclk_s && (hi_cnt >= HI_W'(STBY_CYC - 1));

  wire [DATA_W-1:0] sat_word =
    (conv_raw > HI_LIM) ? {1'b0, {(DATA_W-1){1'b1}}} :
    (conv_raw < LO_LIM) ? {1'b1, {(DATA_W-1){1'b0}}} :
                          conv_raw[DATA_W-1:0];

  assign dout_rdy = (phase == P_RDY) ? 1'b0 : (phase == P_SHIFT) ? sreg[DATA_W-1] : 1'b1;
  assign stby     = phase == P_STBY;
  assign chan_oh  = 4'b0001 << ctl_s[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sclk_d  <= 1'b0;
      ctl_m   <= '0;
      ctl_s   <= '0;
      ctl_d   <= '0;
      hi_cnt  <= '0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_in};
      sclk_d  <= sclk_s;
      ctl_m   <= {sel_in, buf_en_in, temp_en_in};
      ctl_s   <= ctl_m;
      ctl_d   <= ctl_s;
      if (!sclk_s) hi_cnt <= '0;
      else if (hi_cnt < HI_W'(STBY_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      sreg     <= '0;
      bitn     <= '0;
      skip     <= '0;
      cal_req  <= 1'b0;
      cal_pend <= 1'b0;
    end else begin
      cal_req <= 1'b0;
      if (ctl_chg) begin
        skip <= SK_W'(SETTLE - 1);
        if (phase != P_STBY) phase <= P_IDLE;
      end else if (phase == P_STBY) begin
        if (fall) begin
          if (cal_pend) begin
            phase   <= P_CAL;
            skip    <= SK_W'(CAL_SKIP);
            cal_req <= 1'b1;
          end else begin
            phase <= P_IDLE;
          end
        end
      end else if (stby_go) begin
        phase    <= P_STBY;
        cal_pend <= bitn == CNT_W'(DATA_W + 2);
      end else if (conv_tick) begin
        if (skip != '0) skip <= skip - 1'b1;
        else begin
          sreg  <= sat_word;
          bitn  <= '0;
          phase <= P_UPD;
        end
      end else begin
        case (phase)
          P_UPD: phase <= P_RDY;
          P_RDY: if (rise) begin
            phase <= P_SHIFT;
            bitn  <= CNT_W'(1);
          end
          P_SHIFT: if (rise) begin
            if (bitn == CNT_W'(DATA_W)) begin
              phase <= P_HIGH;
              bitn  <= CNT_W'(DATA_W + 1);
            end else begin
              sreg <= sreg << 1;
              bitn <= bitn + 1'b1;
            end
          end
          P_HIGH: begin
            if (rise && bitn == CNT_W'(DATA_W + 1)) bitn <= CNT_W'(DATA_W + 2);
            else if (fall && bitn == CNT_W'(DATA_W + 2)) begin
              phase   <= P_CAL;
              skip    <= SK_W'(CAL_SKIP);
              cal_req <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_CHG_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ctl_chg |=> dout_rdy); // R6
  AST_SKIP_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (skip != '0) |-> dout_rdy); // R6
  AST_CAL_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cal_req |-> dout_rdy); // R5
  AST_CAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cal_req |=> !cal_req); // R5
  AST_STBY_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) stby |-> dout_rdy); // R9
  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) ($fell(stby) && !$past(ctl_chg)) |-> dout_rdy); // R9
endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_tick = 1'b0;
  logic signed [25:0] conv_raw = '0;
  logic sclk = 1'b0;
  logic [1:0] sel = 2'b00;
  logic buf_en = 1'b0;
  logic temp_en = 1'b0;
  logic dout_rdy, cal_req, stby;
  logic [3:0] chan_oh;
  int n_run = 0, n_fail = 0, cal_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .conv_raw(conv_raw),
    .sclk_in(sclk), .sel_in(sel), .buf_en_in(buf_en), .temp_en_in(temp_en),
    .dout_rdy(dout_rdy), .cal_req(cal_req), .stby(stby), .chan_oh(chan_oh));

  always @(negedge clk) if (cal_req) cal_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic sc(input logic v); sclk = v; wt(4); endtask

  task automatic tick(input logic signed [25:0] raw);
    conv_raw = raw; conv_tick = 1'b1;
    @(negedge clk);
    conv_tick = 1'b0;
  endtask

  task automatic present(input logic signed [25:0] raw, input string req);
    tick(raw);
    check({req, " update pulse"}, dout_rdy, 1);
    wt(1);
    check({req, " ready low"}, dout_rdy, 0);
  endtask

  task automatic discard(input string req);
    tick(26'sd77); wt(2);
    check({req, " discarded tick keeps pin high"}, dout_rdy, 1);
  endtask

  task automatic read_bits(input int n, output logic [23:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      sc(1); w = {w[22:0], dout_rdy}; sc(0);
    end
  endtask

  function automatic logic [23:0] sat(input logic signed [25:0] r);
    if (r > 26'sd8388607) return 24'h7FFFFF;
    if (r < -26'sd8388608) return 24'h800000;
    return r[23:0];
  endfunction

  function automatic logic signed [25:0] val(input int k);
    case (k)
      0: return 26'sd0;           1: return 26'sd1;
      2: return -26'sd1;          3: return 26'sd8388607;
      4: return 26'sd8388608;     5: return -26'sd8388608;
      6: return -26'sd8388609;    7: return 26'sd33554431;
      8: return -26'sd33554432;   9: return 26'sd12345;
      10: return -26'sd654321;    default: return 26'sh05A5A5A;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    int c0;
    wt(5);
    check("R1 pin high in reset", dout_rdy, 1);
    check("R1 stby low in reset", stby, 0);
    check("R1 cal_req low in reset", cal_req, 0);
    check("R1 R7 channel one-hot in reset", chan_oh, 4'b0001);
    rst_n = 1'b1; wt(3);

    for (int k = 0; k < 12; k++) begin
      present(val(k), "R2");
      read_bits(24, w);
      check("R3 R8 word read MSB first, clipped", w, sat(val(k)));
      wt(6);
      check("R3 last bit held", dout_rdy, sat(val(k)) & 1);
      sc(1);
      check("R4 25th edge forces high", dout_rdy, 1);
      sc(0);
    end

    for (int c = 0; c < 4; c++) begin
      sel = 2'(c); wt(6);
      check("R7 channel code to one-hot", chan_oh, 4'b0001 << c);
    end
    check("R6 pin high after select change", dout_rdy, 1);
    discard("R6"); discard("R6");
    present(26'sd4242, "R6 settled");

    buf_en = 1'b1; wt(6);
    check("R6 buffer toggle forces high", dout_rdy, 1);
    discard("R6"); discard("R6");
    present(26'sd99, "R6 after buffer");
    temp_en = 1'b1; wt(6);
    check("R6 temp toggle forces high", dout_rdy, 1);
    discard("R6"); discard("R6");
    present(26'sd98, "R6 after temp");

    temp_en = 1'b0; wt(2);
    tick(26'sd5);
    wt(2);
    check("R6 coincident tick pin high", dout_rdy, 1);
    discard("R6 coincident"); discard("R6 coincident");
    present(26'sd6, "R6 coincident tick not counted");

    present(26'sh0ABCDEF, "R11 first");
    read_bits(5, w);
    present(26'sh0123456, "R11 replace");
    read_bits(24, w);
    check("R11 replacement word read", w, 24'h123456);

    present(26'sd1000, "R5 setup");
    read_bits(24, w);
    sc(1); sc(0);
    c0 = cal_cnt;
    sc(1);
    check("R5 no request before 26th fall", cal_cnt, c0);
    sc(0);
    check("R5 one request on 26th fall", cal_cnt, c0 + 1);
    check("R5 pin high in calibration", dout_rdy, 1);
    discard("R5"); discard("R5");
    present(-26'sd3, "R5 first data after calibration");

    present(26'sh0FEDCBA, "R9 setup");
    read_bits(3, w);
    sclk = 1'b1; wt(80);
    check("R9 standby entered", stby, 1);
    check("R9 pin high in standby", dout_rdy, 1);
    tick(26'sd11); wt(2);
    check("R9 tick ignored in standby", dout_rdy, 1);
    sc(0);
    check("R9 standby exited", stby, 0);
    check("R9 pin high after wakeup", dout_rdy, 1);
    present(26'sd321, "R9 data after wakeup");
    read_bits(24, w);
    check("R9 word after wakeup", w, 24'd321);

    sc(1); sc(0);
    c0 = cal_cnt;
    sclk = 1'b1; wt(80);
    check("R10 standby on 26th high", stby, 1);
    check("R10 no request yet", cal_cnt, c0);
    sc(0);
    check("R10 request on wakeup", cal_cnt, c0 + 1);
    check("R10 pin high in calibration", dout_rdy, 1);
    discard("R10"); discard("R10");
    present(26'sd55, "R10 data after calibration");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule